// File: doc/BRIEF.md
# Receive Store-and-Acknowledge Sequencer

This block sits between a packet radio's physical layer and a host processor. It stays idle until the physical layer reports a start-of-frame delimiter. It then copies every received byte into a shared memory, one address after another. It also keeps the first few header bytes in a small local buffer. When the frame ends, it writes the frame length into a fixed slot of the shared memory. It raises the frame-ready pulse only after that length write has happened. If frame-check validation is switched on, a frame whose checksum failed is dropped silently. Such a frame gets no length write, no notification and no acknowledgement.

After it notifies the host, the sequencer reads the buffered header. It sends an acknowledgement when all of these hold:
- the frame asks for one;
- the checksum was good;
- the frame is not itself an acknowledgement.

It does this by starting a three-byte transmission on the physical layer, with the checksum appended by the physical layer. It hands over each byte one at a time, as the transmitter asks for it. Because the whole path is hardware, the transmit start follows the end of reception by four clock cycles. That is a few tens of nanoseconds, far inside the turnaround budget of low-rate personal-area networks.

Top module: `rxack_seq`

## Requirements
- R1: Outside a frame (before any delimiter, or while an acknowledgement is being sent), received bytes and delimiters cause no shared-memory write.
- R2: After a delimiter, received byte i is written to address DATA_BASE+i (default 1) in the cycle after it is presented. Bytes beyond MAX_LEN (default 127) are dropped.
- R3: Two cycles after the end-of-frame strobe, the number of stored bytes is written to address LEN_ADDR (default 0).
- R4: frame_rdy is a one-cycle pulse in the cycle right after the length write.
- R5: With fcs_chk_en high and rx_fcs_ok low at frame end, there is no length write, no frame_rdy and no tx_start.
- R6: With fcs_chk_en low, a frame with a bad checksum is still stored and notified, but it is never acknowledged.
- R7: tx_start pulses one cycle after frame_rdy, with tx_len = 3 and tx_fcs_add = 1, when all of these hold: bit 5 of byte 0 is set, byte 0 bits 2:0 are not 3'b010 (acknowledgement type), the checksum was good, and at least 3 bytes were stored.
- R8: A frame whose bit 5 of byte 0 is clear produces no tx_start, and the sequencer accepts the next delimiter.
- R9: After tx_start, each tx_byte_req is answered in the next cycle by tx_byte_vld with bytes 0x02, 0x00 and then byte 2 of the received frame. Requests after the third get no tx_byte_vld.
- R10: tx_done ends the acknowledgement and returns the sequencer to idle. ack_evt pulses in the next cycle only if ack_evt_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fcs_chk_en | input | 1 | Drop frames with a bad checksum |
| ack_evt_en | input | 1 | Enable the end-of-acknowledgement event |
| rx_sfd | input | 1 | Start-of-frame delimiter seen |
| rx_byte_vld | input | 1 | Received byte valid |
| rx_byte | input | 8 | Received byte |
| rx_end | input | 1 | End of received frame |
| rx_fcs_ok | input | 1 | Checksum status, valid with rx_end |
| mem_we | output | 1 | Shared-memory write strobe |
| mem_addr | output | AW | Shared-memory byte address |
| mem_wdata | output | 8 | Shared-memory write data |
| frame_rdy | output | 1 | Frame available pulse to the host |
| tx_start | output | 1 | Start a transmission |
| tx_len | output | 7 | Transmit length (always 3) |
| tx_fcs_add | output | 1 | Physical layer appends the checksum |
| tx_byte_req | input | 1 | Transmitter requests the next byte |
| tx_byte_vld | output | 1 | Transmit byte valid |
| tx_byte | output | 8 | Transmit byte |
| tx_done | input | 1 | Transmission finished |
| ack_evt | output | 1 | Acknowledgement-sent event to the host |

## Verification
The assertions check ordering rules on every cycle:
- a ready pulse always follows a length write, and never follows a rejected checksum while validation is on;
- each frame-data write traces back to an offered byte;
- a transmit start always follows a ready pulse;
- each transmit byte answers a request;
- the host event answers a transmit completion.

Other behaviours are shown only by the bench scenarios:
- the memory contents and the length value;
- the exact acknowledgement bytes and the copied sequence number;
- the cap at the maximum length;
- the choice between acknowledging and staying silent for each combination of header bits, frame size and checksum mode.

// File: rtl/rxack_pkg.sv
package rxack_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_FIN,
        S_NOTIFY,
        S_TXS,
        S_TXF
    } seq_state_e;

    localparam int          ACK_REQ_BIT = 5;
    localparam logic [2:0]  FT_ACK      = 3'b010;
    localparam int          ACK_LEN     = 3;
    localparam int          SEQ_POS     = 2;
    localparam logic [7:0]  ACK_FC0     = 8'h02;
    localparam logic [7:0]  ACK_FC1     = 8'h00;
endpackage

// File: rtl/rxack_hdr_buf.sv
module rxack_hdr_buf #(
    parameter int HDR_LEN = 3,
    parameter int IW      = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      we,
    input  logic [IW-1:0]             idx,
    input  logic [7:0]                din,
    output logic [HDR_LEN-1:0][7:0]   hdr
);
    logic [HDR_LEN-1:0][7:0] hdr_d, hdr_q;

    for (genvar i = 0; i < HDR_LEN; i++) begin : g_slot
        assign hdr_d[i] = clr                             ? 8'h00 :
                          (we && idx == IW'(i))           ? din   :
                                                            hdr_q[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hdr_q <= '0;
        else        hdr_q <= hdr_d;
    end

    assign hdr = hdr_q;
endmodule

// File: rtl/rxack_ack_fmt.sv
module rxack_ack_fmt
    import rxack_pkg::*;
(
    input  logic [1:0] idx,
    input  logic [7:0] seq,
    output logic [7:0] ack_byte
);
    always_comb begin
        case (idx)
            2'd0:    ack_byte = ACK_FC0;
            2'd1:    ack_byte = ACK_FC1;
            default: ack_byte = seq;
        endcase
    end
endmodule

// File: rtl/rxack_seq.sv
module rxack_seq
    import rxack_pkg::*;
#(
    parameter int AW        = 8,
    parameter int MAX_LEN   = 127,
    parameter int HDR_LEN   = 3,
    parameter int DATA_BASE = 1,
    parameter int LEN_ADDR  = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fcs_chk_en,
    input  logic          ack_evt_en,
    input  logic          rx_sfd,
    input  logic          rx_byte_vld,
    input  logic [7:0]    rx_byte,
    input  logic          rx_end,
    input  logic          rx_fcs_ok,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic          frame_rdy,
    output logic          tx_start,
    output logic [6:0]    tx_len,
    output logic          tx_fcs_add,
    input  logic          tx_byte_req,
    output logic          tx_byte_vld,
    output logic [7:0]    tx_byte,
    input  logic          tx_done,
    output logic          ack_evt
);
    localparam int LW = $clog2(MAX_LEN + 1);

    typedef struct packed {
        seq_state_e    st;
        logic [LW-1:0] cnt;
        logic          fcs_ok;
        logic [1:0]    idx;
        logic          mem_we;
        logic [AW-1:0] mem_addr;
        logic [7:0]    mem_wdata;
        logic          frame_rdy;
        logic          tx_start;
        logic          tx_byte_vld;
        logic [7:0]    tx_byte;
        logic          ack_evt;
    } seq_regs_t;

    seq_regs_t q, d;

    logic                    store;
    logic                    hdr_clr;
    logic [HDR_LEN-1:0][7:0] hdr;
    logic [7:0]              ack_byte;
    logic                    ack_need;

    rxack_hdr_buf #(.HDR_LEN(HDR_LEN), .IW(LW)) u_hdr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (hdr_clr),
        .we    (store && (q.cnt < LW'(HDR_LEN))),
        .idx   (q.cnt),
        .din   (rx_byte),
        .hdr   (hdr)
    );

    rxack_ack_fmt u_fmt (
        .idx      (q.idx),
        .seq      (hdr[SEQ_POS]),
        .ack_byte (ack_byte)
    );

    assign hdr_clr  = (q.st == S_IDLE) && rx_sfd;
    assign ack_need = q.fcs_ok
                   && hdr[0][ACK_REQ_BIT]
                   && (hdr[0][2:0] != FT_ACK)
                   && (q.cnt >= LW'(SEQ_POS + 1));

    always_comb begin
        d             = q;
        d.mem_we      = 1'b0;
        d.frame_rdy   = 1'b0;
        d.tx_start    = 1'b0;
        d.tx_byte_vld = 1'b0;
        d.ack_evt     = 1'b0;
        store         = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (rx_sfd) begin
                    d.st  = S_RX;
                    d.cnt = '0;
                end
            end
            S_RX: begin
                if (rx_byte_vld && q.cnt < LW'(MAX_LEN)) begin
                    store       = 1'b1;
                    d.mem_we    = 1'b1;
                    d.mem_addr  = AW'(DATA_BASE) + AW'(q.cnt);
                    d.mem_wdata = rx_byte;
                    d.cnt       = q.cnt + 1'b1;
                end
                if (rx_end) begin
                    d.fcs_ok = rx_fcs_ok;
                    d.st     = S_FIN;
                end
            end
            S_FIN: begin
                if (fcs_chk_en && !q.fcs_ok) begin
                    d.st = S_IDLE;
                end else begin
                    d.mem_we    = 1'b1;
                    d.mem_addr  = AW'(LEN_ADDR);
                    d.mem_wdata = 8'(q.cnt);
                    d.st        = S_NOTIFY;
                end
            end
            S_NOTIFY: begin
                d.frame_rdy = 1'b1;
                d.st        = ack_need ? S_TXS : S_IDLE;
            end
            S_TXS: begin
                d.tx_start = 1'b1;
                d.idx      = '0;
                d.st       = S_TXF;
            end
            S_TXF: begin
                if (tx_byte_req && q.idx < 2'(ACK_LEN)) begin
                    d.tx_byte_vld = 1'b1;
                    d.tx_byte     = ack_byte;
                    d.idx         = q.idx + 1'b1;
                end
                if (tx_done) begin
                    d.ack_evt = ack_evt_en;
                    d.st      = S_IDLE;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign mem_we      = q.mem_we;
    assign mem_addr    = q.mem_addr;
    assign mem_wdata   = q.mem_wdata;
    assign frame_rdy   = q.frame_rdy;
    assign tx_start    = q.tx_start;
    assign tx_len      = 7'(ACK_LEN);
    assign tx_fcs_add  = 1'b1;
    assign tx_byte_vld = q.tx_byte_vld;
    assign tx_byte     = q.tx_byte;
    assign ack_evt     = q.ack_evt;
endmodule

// File: rtl/rxack_seq_chk.sv
module rxack_seq_chk #(
    parameter int AW       = 8,
    parameter int LEN_ADDR = 0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fcs_chk_en,
    input logic          ack_evt_en,
    input logic          rx_byte_vld,
    input logic          rx_end,
    input logic          rx_fcs_ok,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          frame_rdy,
    input logic          tx_start,
    input logic          tx_byte_req,
    input logic          tx_byte_vld,
    input logic          tx_done,
    input logic          ack_evt
);
    logic fcs_seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      fcs_seen_q <= 1'b0;
        else if (rx_end) fcs_seen_q <= rx_fcs_ok;
    end

    p_data_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_addr != AW'(LEN_ADDR)) |-> $past(rx_byte_vld));

    p_rdy_after_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_rdy |-> ($past(mem_we) && $past(mem_addr) == AW'(LEN_ADDR)));

    p_no_rdy_bad_fcs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_rdy && fcs_chk_en) |-> fcs_seen_q);

    p_start_after_rdy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> $past(frame_rdy));

    p_byte_answers_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_byte_vld |-> $past(tx_byte_req));

    p_evt_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_evt |-> ($past(tx_done) && $past(ack_evt_en)));
endmodule

bind rxack_seq rxack_seq_chk #(.AW(AW), .LEN_ADDR(LEN_ADDR)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fcs_chk_en  (fcs_chk_en),
    .ack_evt_en  (ack_evt_en),
    .rx_byte_vld (rx_byte_vld),
    .rx_end      (rx_end),
    .rx_fcs_ok   (rx_fcs_ok),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .frame_rdy   (frame_rdy),
    .tx_start    (tx_start),
    .tx_byte_req (tx_byte_req),
    .tx_byte_vld (tx_byte_vld),
    .tx_done     (tx_done),
    .ack_evt     (ack_evt)
);

// File: tb/rxack_seq_test.sv
module rxack_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fcs_chk_en = 1'b1, ack_evt_en = 1'b1;
    logic       rx_sfd = 1'b0, rx_byte_vld = 1'b0, rx_end = 1'b0, rx_fcs_ok = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       tx_byte_req = 1'b0, tx_done = 1'b0;
    logic       mem_we, frame_rdy, tx_start, tx_fcs_add, tx_byte_vld, ack_evt;
    logic [7:0] mem_addr, mem_wdata, tx_byte;
    logic [6:0] tx_len;

    rxack_seq uut (.*);

    always #2 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;
    int wr_cnt, len_cnt, last_len, len_cyc, rdy_cnt, rdy_cyc;
    int txs_cnt, txs_cyc, txs_len, txs_fcs, txb_n, evt_cnt, end_cyc;
    logic [7:0] mem_m [0:255];
    logic [7:0] txb   [0:7];
    logic [7:0] frm   [0:255];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (mem_we) begin
            if (mem_addr == 8'd0) begin len_cnt++; last_len = mem_wdata; len_cyc = cyc; end
            else begin mem_m[mem_addr] = mem_wdata; wr_cnt++; end
        end
        if (frame_rdy) begin rdy_cnt++; rdy_cyc = cyc; end
        if (tx_start) begin txs_cnt++; txs_cyc = cyc; txs_len = tx_len; txs_fcs = tx_fcs_add; end
        if (tx_byte_vld) begin if (txb_n < 8) txb[txb_n] = tx_byte; txb_n++; end
        if (ack_evt) evt_cnt++;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr_mon();
        wr_cnt = 0; len_cnt = 0; last_len = -1; len_cyc = -1; rdy_cnt = 0; rdy_cyc = -1;
        txs_cnt = 0; txs_cyc = -1; txs_len = -1; txs_fcs = -1; txb_n = 0; evt_cnt = 0;
    endtask

    task automatic set_frame(input int n, input logic [7:0] b0, input logic [7:0] seq);
        for (int i = 0; i < n; i++) frm[i] = 8'(8'h40 + i);
        frm[0] = b0;
        frm[2] = seq;
    endtask

    task automatic send_frame(input int n, input logic fcs);
        @(negedge clk) rx_sfd = 1'b1;
        @(negedge clk) rx_sfd = 1'b0;
        for (int i = 0; i < n; i++) begin
            rx_byte_vld = 1'b1; rx_byte = frm[i];
            @(negedge clk);
        end
        rx_byte_vld = 1'b0;
        rx_end = 1'b1; rx_fcs_ok = fcs; end_cyc = cyc;
        @(negedge clk) rx_end = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic serve_ack();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk) tx_byte_req = 1'b1;
            @(negedge clk) tx_byte_req = 1'b0;
        end
        @(negedge clk) tx_done = 1'b1;
        @(negedge clk) tx_done = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 reset mem_we", mem_we, 0);
        chk("R4 reset frame_rdy", frame_rdy, 0);
        chk("R7 reset tx_start", tx_start, 0);
        chk("R9 reset tx_byte_vld", tx_byte_vld, 0);
    endtask

    task automatic t_stray();
        clr_mon();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk) rx_byte_vld = 1'b1; rx_byte = 8'(i);
        end
        @(negedge clk) rx_byte_vld = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 no write before delimiter", wr_cnt + len_cnt, 0);
    endtask

    task automatic t_plain();
        bit ok = 1;
        clr_mon(); set_frame(6, 8'h01, 8'h11);
        send_frame(6, 1'b1);
        for (int i = 0; i < 6; i++) if (mem_m[1 + i] !== frm[i]) ok = 0;
        chk("R2 data stored at base+i", int'(ok), 1);
        chk("R2 write count", wr_cnt, 6);
        chk("R3 length value", last_len, 6);
        chk("R3 length two cycles after end", len_cyc, end_cyc + 2);
        chk("R4 single ready pulse", rdy_cnt, 1);
        chk("R4 ready after length", rdy_cyc, len_cyc + 1);
        chk("R8 no ack without request", txs_cnt, 0);
    endtask

    task automatic t_ack(input logic evt_en, input logic [7:0] seq);
        ack_evt_en = evt_en;
        clr_mon(); set_frame(5, 8'h21, seq);
        send_frame(5, 1'b1);
        chk("R7 ack started", txs_cnt, 1);
        chk("R7 start after ready", txs_cyc, rdy_cyc + 1);
        chk("R7 turnaround cycles", txs_cyc, end_cyc + 4);
        chk("R7 tx_len", txs_len, 3);
        chk("R7 tx_fcs_add", txs_fcs, 1);
        wr_cnt = 0;
        @(negedge clk) rx_sfd = 1'b1;
        @(negedge clk) rx_sfd = 1'b0; rx_byte_vld = 1'b1; rx_byte = 8'hEE;
        @(negedge clk) rx_byte_vld = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 no write during ack", wr_cnt, 0);
        serve_ack();
        chk("R9 byte count", txb_n, 3);
        chk("R9 byte0", txb[0], 8'h02);
        chk("R9 byte1", txb[1], 8'h00);
        chk("R9 byte2 sequence", txb[2], seq);
        chk("R10 event", evt_cnt, evt_en ? 1 : 0);
        ack_evt_en = 1'b1;
    endtask

    task automatic t_bad_fcs_checked();
        fcs_chk_en = 1'b1;
        clr_mon(); set_frame(5, 8'h21, 8'h33);
        send_frame(5, 1'b0);
        chk("R5 no length write", len_cnt, 0);
        chk("R5 no ready", rdy_cnt, 0);
        chk("R5 no ack", txs_cnt, 0);
    endtask

    task automatic t_bad_fcs_unchecked();
        fcs_chk_en = 1'b0;
        clr_mon(); set_frame(5, 8'h21, 8'h34);
        send_frame(5, 1'b0);
        chk("R6 notified", rdy_cnt, 1);
        chk("R6 length", last_len, 5);
        chk("R6 no ack", txs_cnt, 0);
        fcs_chk_en = 1'b1;
    endtask

    task automatic t_no_ack_cases();
        clr_mon(); set_frame(5, 8'h22, 8'h35);
        send_frame(5, 1'b1);
        chk("R7 ack-type frame not acked", txs_cnt, 0);
        chk("R8 ack-type frame notified", rdy_cnt, 1);
        clr_mon(); set_frame(2, 8'h21, 8'h00);
        send_frame(2, 1'b1);
        chk("R7 short frame not acked", txs_cnt, 0);
    endtask

    task automatic t_overflow();
        clr_mon();
        for (int i = 0; i < 130; i++) frm[i] = 8'(i);
        frm[0] = 8'h01;
        send_frame(130, 1'b1);
        chk("R2 writes capped", wr_cnt, 127);
        chk("R2 last stored byte", mem_m[127], 8'd126);
        chk("R3 capped length", last_len, 127);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clr_mon();
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_stray();
        t_plain();
        t_ack(1'b1, 8'h5A);
        t_bad_fcs_checked();
        t_bad_fcs_unchecked();
        t_no_ack_cases();
        t_ack(1'b0, 8'hC3);
        t_overflow();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule